// File: doc/BRIEF.md
# Interleaved Priority Interrupt Controller

This block gathers sixteen interrupt sources into one pending register and turns them into a single maskable request to the processor core, together with an 8-bit vector code. Eight sources are active-low external pins and eight are active-high internal levels. Their pending bits alternate: every even bit belongs to a pin and every odd bit belongs to an internal level. Each pin can be set to latch a falling edge or to follow a low level.

A 16-bit enable register decides which pending bits may compete. A fixed-priority arbiter then picks the lowest-numbered enabled source. Pin 0 is not part of the maskable path. It drives its own non-maskable request output and never competes.

The vector code places the winning index in bits 5..2 and keeps every other bit at zero. Software can therefore add the code straight to the base of a table of 4-byte entries. A small register port gives read and write access to the pending, enable and trigger-select registers, and read access to the vector.

Top module: `irq_interleave_ctrl`

## Requirements
- R1: Pending bit 2i+1 equals internal input `int_lvl[i]` as it was sampled at the previous clock edge. Software cannot clear it.
- R2: When trigger bit i is 0 (level mode), pending bit 2i equals the inverse of `ext_pin_n[i]` as it was sampled at the previous clock edge.
- R3: When trigger bit i is 1 (edge mode), pending bit 2i is set one cycle after a high-to-low change of `ext_pin_n[i]`. It stays set while the pin is high again.
- R4: Writing register address 0 with a 1 in bit 2i clears pending bit 2i only if pin i is in edge mode. A falling edge in the same cycle wins over the clear. Level-mode pin bits and internal bits ignore the write.
- R5: An enable bit set to 1 lets its source compete. `core_req` is high exactly when some pending bit 1..15 is set with its enable bit also set.
- R6: Among the enabled pending bits 1..15, the lowest index wins. `vec_code` equals that index shifted left by 2, with bits 7:6 and 1:0 at zero.
- R7: When no source competes, `vec_code` reads 0x00 and `core_req` is low.
- R8: `nmi_req` equals pending bit 0, whatever its enable bit says. Pin 0 never raises `core_req` and never selects a vector.
- R9: The register map is: address 0 is pending, 1 is enable, 2 is trigger select in bits 7:0, and 3 is the vector, read only and zero-extended. `reg_rdata` shows the addressed value as it stood at the edge where `reg_rd` was sampled. It holds that value until the next read.
- R10: After reset, pending, enable, trigger select and `reg_rdata` are all zero. Every pin starts in level mode, and the last-seen pin level is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_n | input | 8 | External request pins, active low |
| int_lvl | input | 8 | Internal level requests, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| core_req | output | 1 | Maskable request to the core |
| nmi_req | output | 1 | Non-maskable request from pin 0 |
| vec_code | output | 8 | Vector code of the winning source |

## Verification
Pending bits, the enable register and the trigger register change at the clock edge that samples the stimulus. `core_req` and `vec_code` are combinational from those registers, so they are due right after that same edge. A read strobe likewise produces its data right after the edge that samples it.

The bench applies inputs 2 ns after a rising edge and waits for one edge. It moves its reference model forward at that edge, then compares all four outputs 2 ns later. Every expectation is therefore exactly one edge away from its stimulus.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    RA_PEND = 2'd0,
    RA_MASK = 2'd1,
    RA_TRIG = 2'd2,
    RA_VEC  = 2'd3
  } reg_addr_e;

  // Bit position of external pin i in the interleaved pending word.
  function automatic int unsigned pin_pos(int unsigned i);
    return 2 * i;
  endfunction

  // Bit position of internal level i in the interleaved pending word.
  function automatic int unsigned lvl_pos(int unsigned i);
    return 2 * i + 1;
  endfunction
endpackage

// File: rtl/irqc_pend_bank.sv
module irqc_pend_bank #(
  parameter int NPIN = 8,
  localparam int NSRC = 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_n,
  input  logic [NPIN-1:0] lvl_in,
  input  logic [NPIN-1:0] trig_edge,
  input  logic [NPIN-1:0] clr_pin,
  output logic [NSRC-1:0] pend,
  output logic [NPIN-1:0] fall_evt
);
  logic [NPIN-1:0] pin_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= '1;
    else        pin_prev <= pin_n;
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_src
    localparam int PB = irqc_pkg::pin_pos(i);
    localparam int LB = irqc_pkg::lvl_pos(i);

    assign fall_evt[i] = pin_prev[i] & ~pin_n[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend[PB] <= 1'b0;
        pend[LB] <= 1'b0;
      end else begin
        if (trig_edge[i]) pend[PB] <= fall_evt[i] | (pend[PB] & ~clr_pin[i]);
        else              pend[PB] <= ~pin_n[i];
        pend[LB] <= lvl_in[i];
      end
    end
  end
endmodule

// File: rtl/irqc_prio_arb.sv
module irqc_prio_arb #(
  parameter int NSRC = 16,
  parameter int VECW = 8,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] cand,
  output logic            any,
  output logic [IDXW-1:0] win_idx,
  output logic [VECW-1:0] vec
);
  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) win_idx = IDXW'(i);
    end
  end

  assign any = |cand;
  assign vec = any ? (VECW'(win_idx) << 2) : '0;
endmodule

// File: rtl/irq_interleave_ctrl.sv
module irq_interleave_ctrl #(
  parameter int NPIN = 8,
  parameter int VECW = 8,
  localparam int NSRC = 2 * NPIN,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] ext_pin_n,
  input  logic [NPIN-1:0] int_lvl,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  output logic            core_req,
  output logic            nmi_req,
  output logic [VECW-1:0] vec_code
);
  import irqc_pkg::*;

  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] mask_q;
  logic [NPIN-1:0] trig_q;
  logic [NPIN-1:0] clr_pin;
  logic [NPIN-1:0] fall_evt;
  logic [NSRC-1:0] cand;
  logic [IDXW-1:0] win_idx;
  reg_addr_e       addr_e;

  assign addr_e = reg_addr_e'(reg_addr);

  for (genvar i = 0; i < NPIN; i++) begin : g_clr
    assign clr_pin[i] = reg_wr && (addr_e == RA_PEND) && reg_wdata[pin_pos(i)];
  end

  irqc_pend_bank #(.NPIN(NPIN)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_n    (ext_pin_n),
    .lvl_in   (int_lvl),
    .trig_edge(trig_q),
    .clr_pin  (clr_pin),
    .pend     (pend_q),
    .fall_evt (fall_evt)
  );

  // Pin 0 goes to the non-maskable path and is removed from arbitration.
  assign cand    = pend_q & mask_q & ~NSRC'(1);
  assign nmi_req = pend_q[0];

  irqc_prio_arb #(.NSRC(NSRC), .VECW(VECW)) u_arb (
    .cand   (cand),
    .any    (core_req),
    .win_idx(win_idx),
    .vec    (vec_code)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '0;
      trig_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && addr_e == RA_MASK) mask_q <= reg_wdata;
      if (reg_wr && addr_e == RA_TRIG) trig_q <= reg_wdata[NPIN-1:0];
      if (reg_rd) begin
        case (addr_e)
          RA_PEND: reg_rdata <= pend_q;
          RA_MASK: reg_rdata <= mask_q;
          RA_TRIG: reg_rdata <= NSRC'(trig_q);
          default: reg_rdata <= NSRC'(vec_code);
        endcase
      end
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NPIN = 8,
  parameter int VECW = 8,
  localparam int NSRC = 2 * NPIN,
  localparam int IDXW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] int_lvl,
  input logic            reg_rd,
  input logic [NSRC-1:0] reg_rdata,
  input logic            core_req,
  input logic            nmi_req,
  input logic [VECW-1:0] vec_code,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NPIN-1:0] trig_q,
  input logic [NPIN-1:0] clr_pin
);
  logic            seen;
  logic [IDXW-1:0] vidx;
  logic [NSRC-1:0] above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  assign vidx  = vec_code[IDXW+1:2];
  assign above = ((NSRC'(1) << vidx) - NSRC'(1)) & ~NSRC'(1);

  AST_IDLE_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    !core_req |-> vec_code == '0); // R7

  AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    vec_code[1:0] == 2'b00 && (vec_code >> (IDXW + 2)) == '0); // R6

  AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (pend_q[vidx] && mask_q[vidx] && vidx != '0)); // R6

  AST_NO_BETTER: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> (pend_q & mask_q & above) == '0); // R6

  AST_NMI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && (pend_q[NSRC-1:1] & mask_q[NSRC-1:1]) == '0) |-> (nmi_req && !core_req)); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(reg_rd)) |-> $stable(reg_rdata)); // R9

  for (genvar i = 0; i < NPIN; i++) begin : g_src
    AST_LVL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      seen |-> pend_q[2*i+1] == $past(int_lvl[i])); // R1

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(trig_q[i]) && $past(pend_q[2*i]) && !$past(clr_pin[i])) |-> pend_q[2*i]); // R3
  end
endmodule

bind irq_interleave_ctrl irqc_checker #(.NPIN(NPIN), .VECW(VECW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .int_lvl  (int_lvl),
  .reg_rd   (reg_rd),
  .reg_rdata(reg_rdata),
  .core_req (core_req),
  .nmi_req  (nmi_req),
  .vec_code (vec_code),
  .pend_q   (pend_q),
  .mask_q   (mask_q),
  .trig_q   (trig_q),
  .clr_pin  (clr_pin)
);

// File: tb/tb_irq_interleave_ctrl.sv
`timescale 1ns/1ps
module tb_irq_interleave_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_n = 8'hFF;
  logic [7:0]  lvl = 8'h00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        req, nmi;
  logic [7:0]  vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_pend = 0, m_mask = 0, m_rd = 0;
  logic [7:0]  m_trig = 0, m_prev = 8'hFF;

  always #4 clk = ~clk;

  irq_interleave_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_n(pin_n), .int_lvl(lvl),
    .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .core_req(req), .nmi_req(nmi), .vec_code(vec)
  );

  function automatic logic [15:0] contenders(logic [15:0] p, logic [15:0] m);
    return p & m & 16'hFFFE;
  endfunction

  function automatic logic [7:0] exp_vec(logic [15:0] p, logic [15:0] m);
    logic [15:0] c = contenders(p, m);
    for (int k = 1; k < 16; k++) if (c[k]) return 8'(k * 4);
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R5 core_req", 16'(req), 16'(contenders(m_pend, m_mask) != 0));
    chk("R6 vec_code", 16'(vec), 16'(exp_vec(m_pend, m_mask)));
    chk("R8 nmi_req", 16'(nmi), 16'(m_pend[0]));
    chk("R9 reg_rdata", rdata, m_rd);
  endtask

  // Advance one edge with the current inputs, update the model, compare.
  task automatic step();
    logic [15:0] np = m_pend;
    for (int i = 0; i < 8; i++) begin
      if (m_trig[i]) begin
        logic fall = m_prev[i] & ~pin_n[i];
        logic clr = wr && addr == 2'd0 && wdata[2*i];
        np[2*i] = fall | (m_pend[2*i] & ~clr);
      end else begin
        np[2*i] = ~pin_n[i];
      end
      np[2*i+1] = lvl[i];
    end
    if (rd) begin
      case (addr)
        2'd0: m_rd = m_pend;
        2'd1: m_rd = m_mask;
        2'd2: m_rd = {8'h00, m_trig};
        default: m_rd = {8'h00, exp_vec(m_pend, m_mask)};
      endcase
    end
    if (wr && addr == 2'd1) m_mask = wdata;
    if (wr && addr == 2'd2) m_trig = wdata[7:0];
    m_prev = pin_n;
    m_pend = np;
    @(posedge clk);
    #2;
    compare_all();
  endtask

  task automatic write(logic [1:0] a, logic [15:0] d);
    wr = 1; addr = a; wdata = d; rd = 0;
    step();
    wr = 0;
  endtask

  task automatic read(logic [1:0] a);
    rd = 1; addr = a; wr = 0;
    step();
    rd = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R10: reset state
    chk("R10 rdata", rdata, 16'h0);
    chk("R10 core_req", 16'(req), 16'h0);
    chk("R10 nmi_req", 16'(nmi), 16'h0);
    chk("R7 idle vec", 16'(vec), 16'h0);
    read(2'd2);
    chk("R10 trig", rdata, 16'h0);

    write(2'd1, 16'hFFFE);
    lvl = 8'h01; step();
    chk("R1 level0 vec", 16'(vec), 16'h0004);
    pin_n = 8'hF7; step();
    read(2'd0);
    chk("R2 pending with pin3 low", rdata, 16'h0042);
    lvl = 8'h00; step();
    chk("R1 level0 dropped vec", 16'(vec), 16'h0018);
    write(2'd2, 16'h0004);
    pin_n = 8'hF3; step();
    chk("R3 edge pin2 latched vec", 16'(vec), 16'h0010);
    pin_n = 8'hF7; step();
    chk("R3 edge pin2 held vec", 16'(vec), 16'h0010);
    write(2'd0, 16'h0052);
    chk("R4 clear edge bit vec", 16'(vec), 16'h0018);
    read(2'd0);
    chk("R4 level bit survives clear", rdata, 16'h0040);
    pin_n = 8'hF6; step();
    chk("R8 nmi on pin0", 16'(nmi), 16'h1);
    write(2'd1, 16'hFFBE);
    chk("R7 all masked req", 16'(req), 16'h0);
    chk("R7 all masked vec", 16'(vec), 16'h0);
    chk("R8 nmi ignores mask", 16'(nmi), 16'h1);
    read(2'd1);
    chk("R9 mask readback", rdata, 16'hFFBE);
    step();
    chk("R9 rdata held", rdata, 16'hFFBE);
    pin_n = 8'hFF; write(2'd1, 16'hFFFF);

    for (int n = 0; n < 3000; n++) begin
      pin_n = 8'($urandom) | 8'($urandom);
      lvl   = 8'($urandom) & 8'($urandom) & 8'($urandom);
      wr    = ($urandom % 6) == 0;
      rd    = ($urandom % 2) == 0;
      addr  = 2'($urandom);
      wdata = 16'($urandom);
      step();
    end
    wr = 0; rd = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule